// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 64-bit virtual address into a physical address by walking a three-level radix page table in memory. A request carries the virtual address, the kind of access (read, write or execute) and whether the requester runs in user or kernel mode. A page table base input supplies the page number of the first-level table. The walker reads one 8-byte table entry per level over a simple read port, and never has more than one read in flight.

Pages are 8 KB. The 43 translated address bits hold three 10-bit table indices above a 13-bit offset, and the offset is copied into the result unchanged. Addresses that are not properly sign-extended, or that a user-mode request makes outside the low user segment, are rejected before any memory traffic. The kernel direct-physical segment bypasses the tables. When a walk ends, the walker gives a one-cycle completion pulse. The pulse carries the physical page number, the four rights bits of the leaf entry, the physical address and a two-bit fault code.

Top module: `va_walker`

## Requirements
- R1: On a successful walk, `done_pa` equals the low `PA_W` bits of {page number, va[12:0]}, so the 13 offset bits pass through unchanged.
- R2: Entry reads use address = table_page*8192 + index*8, where the level-1, level-2 and level-3 indices are va[42:33], va[32:23] and va[22:13], read in that order. A pending read keeps its address until it is accepted.
- R3: The level-1 table page comes from `ptbr_ppn`. Each later table page, and the final page number, is entry bits [63:32] of the entry read one level before.
- R4: If an entry read at any level has bit 0 (valid) clear, the walk stops with no further reads and reports fault code 2. Any fault reports page number 0 and rights 0.
- R5: The leaf entry holds kernel read in bit 8, kernel write in bit 9, user read in bit 12 and user write in bit 13. Access codes are 0 read, 1 write and 2 execute, and execute is checked as a read. A request that lacks the right reports fault code 3. A success reports `done_perm` = {bit13, bit12, bit9, bit8}.
- R6: If va[63:43] is not all copies of va[42], the walker reports fault code 1 and makes no memory read.
- R7: A user-mode request with va[42] = 1 reports fault code 1 and makes no memory read.
- R8: A kernel request with va[42:41] = 2'b10 makes no memory read. It reports fault 0, page number va[33:13] zero-extended, rights 4'b0011 and `done_pa` = va[33:0].
- R9: `req_ready` is high only when idle. `done` is high for exactly one cycle per accepted request. At most one read is outstanding.
- R10: After reset the walker is idle: `req_ready` = 1, `done` = 0, `mem_req_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| ptbr_ppn | input | 32 | Page number of the level-1 table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 45 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle completion pulse |
| done_ppn | output | 32 | Translated page number |
| done_perm | output | 4 | Leaf rights {uw, ur, kw, kr} |
| done_fault | output | 2 | 0 none, 1 address, 2 page, 3 protection |
| done_pa | output | 34 | Physical address |

## Verification
On every cycle, the assertions check the handshake rules:
- the single-cycle completion pulse;
- no acceptance while busy;
- a stable read address under backpressure;
- responses arriving only while a read is outstanding;
- zeroed results on faults;
- rejection of user access to the upper half in the cycle after acceptance.

The bench's walks over a prepared table set are the only way to show the rest. That covers correct index slicing, the level-to-level chaining of table bases, the rights decoding of each mode and access kind, the number and addresses of reads per walk, and the direct-physical bypass. Those are compared against a reference translation computed separately in the bench.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ADDR = 2'd1,
    FLT_PAGE = 2'd2,
    FLT_PROT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    W_IDLE,
    W_ISSUE,
    W_WAIT,
    W_DONE
  } wstate_e;

  // entry field positions
  localparam int PTE_V_BIT    = 0;
  localparam int PTE_KR_BIT   = 8;
  localparam int PTE_KW_BIT   = 9;
  localparam int PTE_UR_BIT   = 12;
  localparam int PTE_UW_BIT   = 13;
  localparam int PTE_PPN_LSB  = 32;
  localparam int PTE_SHIFT    = 3;   // log2 of entry size in bytes

  // positions inside the four-bit rights vector {uw, ur, kw, kr}
  localparam int RT_KR = 0;
  localparam int RT_KW = 1;
  localparam int RT_UR = 2;
  localparam int RT_UW = 3;

  // rights reported for the direct-physical segment: kernel read and write
  localparam logic [3:0] PHYS_RIGHTS = 4'b0011;

endpackage

// File: rtl/walk_seg_check.sv
module walk_seg_check #(
  parameter int XLEN = 64,
  parameter int VA_W = 43
) (
  input  logic [XLEN-1:VA_W-2] va_hi,
  input  logic                 user,
  output logic                 addr_fault,
  output logic                 phys_seg
);
  localparam int EXT_W = XLEN - VA_W + 1;   // sign copies plus the top bit

  logic [EXT_W-1:0] ext_bits;
  logic             canon_ok;
  logic             top_bit;
  logic             next_bit;

  assign ext_bits = va_hi[XLEN-1:VA_W-1];
  assign top_bit  = va_hi[VA_W-1];
  assign next_bit = va_hi[VA_W-2];

  always_comb begin
    canon_ok   = (&ext_bits) | ~(|ext_bits);
    addr_fault = !canon_ok || (user && top_bit);
    phys_seg   = top_bit && !next_bit;
  end

endmodule

// File: rtl/walk_rights.sv
module walk_rights
  import walk_pkg::*;
(
  input  logic [3:0] rights,
  input  logic [1:0] acc,
  input  logic       user,
  output logic       allow
);
  function automatic logic need_write(input logic [1:0] a);
    return a == ACC_WR;   // execute and reserved codes check as reads
  endfunction

  always_comb begin
    if (user)
      allow = need_write(acc) ? rights[RT_UW] : rights[RT_UR];
    else
      allow = need_write(acc) ? rights[RT_KW] : rights[RT_KR];
  end

endmodule

// File: rtl/walk_engine.sv
module walk_engine
  import walk_pkg::*;
#(
  parameter int VA_W   = 43,
  parameter int OFF_W  = 13,
  parameter int IDX_W  = 10,
  parameter int LEVELS = 3,
  parameter int PPN_W  = 32,
  parameter int PA_W   = 34,
  parameter int DATA_W = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_va,
  input  logic [1:0]             req_acc,
  input  logic                   req_user,
  input  logic [PPN_W-1:0]       ptbr_ppn,
  input  logic                   addr_fault,
  input  logic                   phys_seg,
  output logic [1:0]             held_acc,
  output logic                   held_user,
  input  logic                   leaf_allow,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [PPN_W+OFF_W-1:0] mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [DATA_W-1:0]      mem_rsp_data,
  output logic                   done,
  output logic [PPN_W-1:0]       done_ppn,
  output logic [3:0]             done_perm,
  output logic [1:0]             done_fault,
  output logic [PA_W-1:0]        done_pa
);
  localparam int MA_W  = PPN_W + OFF_W;
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int SEGP_W = PA_W - OFF_W;

  function automatic logic [MA_W-1:0] entry_addr(input logic [PPN_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
    return {base, {OFF_W{1'b0}}} + (MA_W'(idx) << PTE_SHIFT);
  endfunction

  function automatic logic [3:0] rights_of(input logic [DATA_W-1:0] pte);
    return {pte[PTE_UW_BIT], pte[PTE_UR_BIT], pte[PTE_KW_BIT], pte[PTE_KR_BIT]};
  endfunction

  wstate_e          state;
  logic [LVL_W-1:0] lvl;
  logic [PPN_W-1:0] base;
  logic [VA_W-1:0]  va_h;
  logic [PPN_W-1:0] res_ppn;
  logic [3:0]       res_perm;
  logic [1:0]       res_fault;

  // named internal events
  logic req_fire;
  logic read_fire;
  logic rsp_take;
  logic pte_invalid;
  logic level_last;
  logic leaf_hit;
  logic [PPN_W-1:0] pte_ppn;
  logic [IDX_W-1:0] cur_idx;
  logic unused_rsp;

  logic [IDX_W-1:0] lvl_idx [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign lvl_idx[g] = va_h[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign cur_idx     = lvl_idx[lvl];
  assign req_ready   = (state == W_IDLE);
  assign req_fire    = req_valid && req_ready;
  assign mem_req_valid = (state == W_ISSUE);
  assign mem_req_addr  = entry_addr(base, cur_idx);
  assign read_fire   = mem_req_valid && mem_req_ready;
  assign rsp_take    = (state == W_WAIT) && mem_rsp_valid;
  assign pte_invalid = !mem_rsp_data[PTE_V_BIT];
  assign level_last  = (lvl == LVL_W'(LEVELS-1));
  assign leaf_hit    = rsp_take && !pte_invalid && level_last;
  assign pte_ppn     = mem_rsp_data[PTE_PPN_LSB +: PPN_W];
  assign unused_rsp  = ^mem_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= W_IDLE;
      lvl       <= '0;
      base      <= '0;
      va_h      <= '0;
      held_acc  <= '0;
      held_user <= 1'b0;
      res_ppn   <= '0;
      res_perm  <= '0;
      res_fault <= FLT_NONE;
    end else begin
      case (state)
        W_IDLE: if (req_fire) begin
          va_h      <= req_va;
          held_acc  <= req_acc;
          held_user <= req_user;
          lvl       <= '0;
          base      <= ptbr_ppn;
          res_ppn   <= '0;
          res_perm  <= '0;
          res_fault <= FLT_NONE;
          if (addr_fault) begin
            res_fault <= FLT_ADDR;
            state     <= W_DONE;
          end else if (phys_seg) begin
            res_ppn   <= PPN_W'(req_va[PA_W-1:OFF_W]);
            res_perm  <= PHYS_RIGHTS;
            state     <= W_DONE;
          end else begin
            state     <= W_ISSUE;
          end
        end
        W_ISSUE: if (read_fire) state <= W_WAIT;
        W_WAIT: if (rsp_take) begin
          if (pte_invalid) begin
            res_fault <= FLT_PAGE;
            state     <= W_DONE;
          end else if (level_last) begin
            if (leaf_allow) begin
              res_ppn  <= pte_ppn;
              res_perm <= rights_of(mem_rsp_data);
            end else begin
              res_fault <= FLT_PROT;
            end
            state <= W_DONE;
          end else begin
            base  <= pte_ppn;
            lvl   <= lvl + 1'b1;
            state <= W_ISSUE;
          end
        end
        W_DONE: state <= W_IDLE;
        default: state <= W_IDLE;
      endcase
    end
  end

  assign done       = (state == W_DONE);
  assign done_ppn   = res_ppn;
  assign done_perm  = res_perm;
  assign done_fault = res_fault;
  assign done_pa    = {res_ppn[SEGP_W-1:0], va_h[OFF_W-1:0]};

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: no second request is accepted while a walk runs
  p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

  // R9: read data only arrives while one read is outstanding
  p_rsp_when_waiting_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> state == W_WAIT);

  // R2: a pending read holds its address under backpressure
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R4: every fault reports a zero page number and zero rights
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault != FLT_NONE |-> done_ppn == '0 && done_perm == '0);

  // R7: user request into the upper half ends next cycle with an address fault
  p_user_seg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && req_user && req_va[VA_W-1] |=> done && done_fault == FLT_ADDR);

  // R6: a rejected address never produces a memory read
  p_addr_fault_nomem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && addr_fault |=> !mem_req_valid);

endmodule

// File: rtl/va_walker.sv
module va_walker
  import walk_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int VA_W   = 43,
  parameter int OFF_W  = 13,
  parameter int IDX_W  = 10,
  parameter int LEVELS = 3,
  parameter int PPN_W  = 32,
  parameter int PA_W   = 34
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [XLEN-1:0]        req_va,
  input  logic [1:0]             req_acc,
  input  logic                   req_user,
  input  logic [PPN_W-1:0]       ptbr_ppn,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [PPN_W+OFF_W-1:0] mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [XLEN-1:0]        mem_rsp_data,
  output logic                   done,
  output logic [PPN_W-1:0]       done_ppn,
  output logic [3:0]             done_perm,
  output logic [1:0]             done_fault,
  output logic [PA_W-1:0]        done_pa
);
  logic       addr_fault;
  logic       phys_seg;
  logic [1:0] held_acc;
  logic       held_user;
  logic       leaf_allow;
  logic [3:0] leaf_rights;

  assign leaf_rights = {mem_rsp_data[PTE_UW_BIT], mem_rsp_data[PTE_UR_BIT],
                        mem_rsp_data[PTE_KW_BIT], mem_rsp_data[PTE_KR_BIT]};

  walk_seg_check #(.XLEN(XLEN), .VA_W(VA_W)) i_seg (
    .va_hi      (req_va[XLEN-1:VA_W-2]),
    .user       (req_user),
    .addr_fault (addr_fault),
    .phys_seg   (phys_seg)
  );

  walk_rights i_rights (
    .rights (leaf_rights),
    .acc    (held_acc),
    .user   (held_user),
    .allow  (leaf_allow)
  );

  walk_engine #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS),
    .PPN_W(PPN_W), .PA_W(PA_W), .DATA_W(XLEN)
  ) i_engine (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va[VA_W-1:0]),
    .req_acc       (req_acc),
    .req_user      (req_user),
    .ptbr_ppn      (ptbr_ppn),
    .addr_fault    (addr_fault),
    .phys_seg      (phys_seg),
    .held_acc      (held_acc),
    .held_user     (held_user),
    .leaf_allow    (leaf_allow),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (done),
    .done_ppn      (done_ppn),
    .done_perm     (done_perm),
    .done_fault    (done_fault),
    .done_pa       (done_pa)
  );

endmodule

// File: tb/test_va_walker.sv
module test_va_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic [31:0] ptbr_ppn = 32'h100;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [44:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [31:0] done_ppn;
  logic [3:0]  done_perm;
  logic [1:0]  done_fault;
  logic [33:0] done_pa;

  va_walker i_va_walker (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // ---------------- memory model ----------------
  logic [63:0] pmem [logic [44:0]];
  logic [44:0] pend_addr = '0;
  int          pend_cnt = 0;
  int          cyc = 0;
  logic [44:0] log_addr [3];
  int          log_n = 0;

  function automatic logic [63:0] rd(input logic [44:0] a);
    return pmem.exists(a) ? pmem[a] : 64'h0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= ((cyc % 4) != 2);
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      pend_addr <= mem_req_addr;
      pend_cnt  <= 2;
      if (log_n < 3) log_addr[log_n] <= mem_req_addr;
      log_n <= log_n + 1;
    end else if (pend_cnt == 2) begin
      pend_cnt <= 1;
    end else if (pend_cnt == 1) begin
      pend_cnt      <= 0;
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= rd(pend_addr);
    end
  end

  function automatic logic [63:0] mk_pte(input logic [31:0] ppn, input logic [3:0] rt,
                                         input logic v);
    return {ppn, 18'h0, rt[3], rt[2], 2'b00, rt[1], rt[0], 7'h0, v};
  endfunction

  task automatic put(input logic [31:0] tbl, input int idx, input logic [63:0] val);
    pmem[{tbl, 13'h0} + 45'(idx) * 45'd8] = val;
  endtask

  function automatic logic [63:0] mkva(input int l1, input int l2, input int l3, input int off);
    logic [42:0] v;
    v = {l1[9:0], l2[9:0], l3[9:0], off[12:0]};
    return {{21{v[42]}}, v};
  endfunction

  // ---------------- reference translation ----------------
  logic [31:0] exp_ppn;
  logic [3:0]  exp_perm;
  logic [1:0]  exp_flt;
  int          exp_n;
  logic [44:0] exp_addr [3];

  task automatic ref_walk(input logic [63:0] va, input logic [1:0] acc, input logic user,
                          input logic [31:0] root);
    logic [31:0] b;
    logic [63:0] e;
    logic [9:0]  ix;
    logic        ok;
    exp_ppn = '0; exp_perm = '0; exp_flt = 2'd0; exp_n = 0;
    if (!(va[63:42] == '0 || va[63:42] == '1)) begin
      exp_flt = 2'd1;
    end else if (user && va[42]) begin
      exp_flt = 2'd1;
    end else if (va[42:41] == 2'b10) begin
      exp_ppn = {11'h0, va[33:13]};
      exp_perm = 4'b0011;
    end else begin
      b = root;
      for (int l = 0; l < 3; l++) begin
        ix = 10'((va >> (13 + 10*(2-l))) & 64'h3ff);
        exp_addr[l] = 45'(b) * 45'd8192 + 45'(ix) * 45'd8;
        exp_n = l + 1;
        e = rd(exp_addr[l]);
        if (e[0] == 1'b0) begin
          exp_flt = 2'd2;
          break;
        end
        if (l < 2) begin
          b = e[63:32];
        end else begin
          if (user) ok = (acc == 2'd1) ? e[13] : e[12];
          else      ok = (acc == 2'd1) ? e[9]  : e[8];
          if (ok) begin
            exp_ppn  = e[63:32];
            exp_perm = {e[13], e[12], e[9], e[8]};
          end else begin
            exp_flt = 2'd3;
          end
        end
      end
    end
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] f, input logic [63:0] va);
    if (f == 2'd2) return "R4";
    if (f == 2'd3) return "R5";
    if (f == 2'd1) return (va[63:42] == '0 || va[63:42] == '1) ? "R7" : "R6";
    if (va[42:41] == 2'b10) return "R8";
    return "R3";
  endfunction

  // ---------------- walk driver ----------------
  task automatic run_walk(input logic [63:0] va, input logic [1:0] acc, input logic user,
                          input logic [1:0] tbl_flt, input string rq);
    int n;
    ref_walk(va, acc, user, ptbr_ppn);
    @(negedge clk);
    log_n = 0;
    req_va = va; req_acc = acc; req_user = user; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R9", "ready before request", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", "ready while busy", 64'(req_ready), 64'd0);
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R9", "walk completes", 64'(done), 64'd1);
    chk(done_fault == tbl_flt, rq, "fault vs table", 64'(done_fault), 64'(tbl_flt));
    chk(done_fault == exp_flt, rq, "fault vs reference", 64'(done_fault), 64'(exp_flt));
    chk(done_ppn == exp_ppn, (exp_flt != 0) ? "R4" : "R3", "page number",
        64'(done_ppn), 64'(exp_ppn));
    chk(done_perm == exp_perm, "R5", "rights", 64'(done_perm), 64'(exp_perm));
    if (exp_flt == 2'd0)
      chk(done_pa == {exp_ppn[20:0], va[12:0]}, "R1", "physical address",
          64'(done_pa), 64'({exp_ppn[20:0], va[12:0]}));
    chk(log_n == exp_n, (exp_n == 0) ? "R6" : "R2", "read count", 64'(log_n), 64'(exp_n));
    for (int k = 0; k < 3; k++)
      if (k < exp_n && k < log_n)
        chk(log_addr[k] == exp_addr[k], "R2", "entry address",
            64'(log_addr[k]), 64'(exp_addr[k]));
    @(negedge clk);
    chk(done == 1'b0, "R9", "single-cycle done", 64'(done), 64'd0);
  endtask

  // ---------------- vector table: {va, acc, user, expected fault} ----------------
  localparam int NV = 17;
  localparam logic [68:0] VECS [NV] = '{
    {mkva(1, 2, 3, 'h123),   2'd0, 1'b1, 2'd0},
    {mkva(1, 2, 3, 'h123),   2'd1, 1'b1, 2'd3},
    {mkva(1, 2, 3, 0),       2'd1, 1'b0, 2'd0},
    {mkva(1, 2, 4, 'h1fff),  2'd1, 1'b1, 2'd0},
    {mkva(1, 2, 4, 0),       2'd2, 1'b1, 2'd0},
    {mkva(1, 2, 5, 0),       2'd0, 1'b0, 2'd2},
    {mkva(1, 7, 0, 0),       2'd0, 1'b0, 2'd2},
    {mkva(9, 0, 0, 0),       2'd0, 1'b1, 2'd2},
    {mkva(1, 2, 6, 8),       2'd2, 1'b0, 2'd0},
    {mkva(1, 2, 6, 8),       2'd1, 1'b0, 2'd3},
    {mkva(1, 2, 6, 8),       2'd0, 1'b1, 2'd3},
    {mkva('h300, 2, 3, 5),   2'd0, 1'b1, 2'd1},
    {mkva('h300, 2, 3, 5),   2'd1, 1'b0, 2'd0},
    {mkva('h200, 5, 7, 'h10), 2'd0, 1'b0, 2'd0},
    {mkva('h200, 5, 7, 'h10), 2'd0, 1'b1, 2'd1},
    {mkva(1, 2, 3, 0) ^ 64'h0004_0000_0000_0000, 2'd0, 1'b0, 2'd1},
    {64'h0000_0400_0000_0000, 2'd0, 1'b0, 2'd1}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err);
    $finish;
  end

  initial begin : main
    // tables: level 1 at 0x100, level 2 at 0x200, level 3 at 0x300
    put(32'h100, 1,     mk_pte(32'h200, 4'b0000, 1'b1));
    put(32'h100, 'h300, mk_pte(32'h200, 4'b0000, 1'b1));
    put(32'h200, 2,     mk_pte(32'h300, 4'b0000, 1'b1));
    put(32'h300, 3,     mk_pte(32'h1abc, 4'b0111, 1'b1));
    put(32'h300, 4,     mk_pte(32'h2222, 4'b1100, 1'b1));
    put(32'h300, 5,     mk_pte(32'h3333, 4'b1111, 1'b0));
    put(32'h300, 6,     mk_pte(32'h0777, 4'b0001, 1'b1));

    repeat (3) @(negedge clk);
    // R10: reset state
    chk(req_ready == 1'b1, "R10", "ready in reset", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R10", "done in reset", 64'(done), 64'd0);
    chk(mem_req_valid == 1'b0, "R10", "no read in reset", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1 && !done && !mem_req_valid, "R10", "idle after reset",
        64'({req_ready, done, mem_req_valid}), 64'b100);

    for (int i = 0; i < NV; i++) begin
      logic [68:0] v;
      v = VECS[i];
      run_walk(v[68:5], v[4:3], v[2], v[1:0], tag_of(v[1:0], v[68:5]));
    end

    // R3: a different base gives a different walk (empty level-1 table -> page fault)
    ptbr_ppn = 32'h400;
    run_walk(mkva(1, 2, 3, 'h44), 2'd0, 1'b0, 2'd2, "R3");
    // R3: a base whose level-1 entry chains to the same tables succeeds again
    put(32'h400, 1, mk_pte(32'h200, 4'b0000, 1'b1));
    run_walk(mkva(1, 2, 3, 'h44), 2'd0, 1'b0, 2'd0, "R3");
    ptbr_ppn = 32'h100;
    // R1: highest offset value carried through a kernel read
    run_walk(mkva(1, 2, 6, 'h1fff), 2'd0, 1'b0, 2'd0, "R1");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule